// File: doc/BRIEF.md
# Serial Packet Receive Deframer

This block sits between a bit-level line receiver and a protocol engine. Each time the enable strobe is high it takes one recovered line level and a single-ended-zero flag. It turns that serial stream into bytes. In normal operation it undoes NRZI coding, hunts for the synchronisation preamble, drops the stuffed bits, and packs the remaining bits into bytes. Each finished byte is presented for exactly one parallel clock.

The protocol engine sees three qualifiers. `rx_active` spans the packet from the end of the preamble to the end-of-packet marker. `rx_valid` marks the cycles in which `rx_data` carries a fresh byte. `rx_error` reports a stuffing violation, which also aborts the packet. A raw-mode input turns off the NRZI decoding and the stuff-bit removal, so that test patterns can be received unchanged. The parallel clock must run at least as fast as the bit strobe, so at most one bit arrives per clock.

Top module: `rxd_deframer`

## Requirements
- R1: In normal mode a line level equal to the previous strobe's level decodes as 1 and a change decodes as 0. The remembered level is 1 (idle J) after reset and after any strobe with `se0` high.
- R2: While idle, a decoded 1 that follows at least SYNC_MIN_ZEROS (default 5) consecutive decoded 0s completes the preamble. `rx_active` is high from the cycle after that strobe. No preamble bit is ever delivered, so the first byte is the one that follows.
- R3: `rx_valid` is high for exactly the one cycle after the strobe that carried a byte's last data bit, with the byte on `rx_data`. It is high only while `rx_active` is high, and it stays low in every other cycle.
- R4: Data bits are packed least-significant bit first: the first bit after the preamble is `rx_data[0]`.
- R5: In normal mode, once six consecutive decoded 1s have been seen, a following decoded 0 is discarded and not counted as data. The preamble's closing 1 counts toward that run.
- R6: In normal mode, a decoded 1 arriving after six consecutive 1s raises `rx_error` for one cycle. In that same cycle `rx_active` falls, and the block returns to hunting for a preamble.
- R7: A strobe with `se0` high during a packet ends it: `rx_active` is low from the next cycle, and any partially packed byte is dropped without an `rx_valid` pulse.
- R8: With `raw_mode` high, the line level is taken directly as the data bit. No bit is removed and `rx_error` never rises. Preamble detection applies the R2 rule to the raw levels.
- R9: After reset `rx_active`, `rx_valid` and `rx_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One recovered bit is present this cycle |
| line_bit | input | 1 | Recovered line level (1 = J) |
| se0 | input | 1 | Both line wires low at this strobe |
| raw_mode | input | 1 | Bypass NRZI decoding and stuff-bit removal |
| rx_data | output | DATA_W | Last completed byte |
| rx_valid | output | 1 | `rx_data` holds a new byte this cycle |
| rx_active | output | 1 | Inside a packet |
| rx_error | output | 1 | One-cycle stuffing-violation flag |

## Verification
The assertions assume that `bit_en` is sampled once per clock and that `line_bit` and `se0` matter only when `bit_en` is high. They also assume that `raw_mode` stays constant for the whole of a packet. The bench drives every strobe from one task on the falling edge. It changes `raw_mode` only between packets, after the end-of-packet marker and an idle J. It uses strobes both back-to-back and with spacing, so that `rx_valid` gaps from stuffing and from strobe spacing both occur.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam logic IDLE_LEVEL = 1'b1;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } frame_state_t;

    typedef struct packed {
        logic strobe;
        logic se0;
        logic value;
    } sym_t;

    function automatic logic nrzi_bit(input logic cur, input logic prev);
        return ~(cur ^ prev);
    endfunction

endpackage

// File: rtl/rxd_line_decode.sv
module rxd_line_decode
    import rxd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic line_bit,
    input  logic se0,
    input  logic raw_mode,
    output sym_t sym
);
    logic prev_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_level <= IDLE_LEVEL;
        end else if (bit_en) begin
            prev_level <= se0 ? IDLE_LEVEL : line_bit;
        end
    end

    always_comb begin
        sym.strobe = bit_en;
        sym.se0    = se0;
        sym.value  = raw_mode ? line_bit : nrzi_bit(line_bit, prev_level);
    end
endmodule

// File: rtl/rxd_frame_ctrl.sv
module rxd_frame_ctrl
    import rxd_pkg::*;
#(
    parameter int SYNC_MIN_ZEROS = 5,
    parameter int STUFF_RUN      = 6
) (
    input  logic clk,
    input  logic rst,
    input  sym_t sym,
    input  logic raw_mode,
    output logic take,
    output logic take_val,
    output logic frame_start,
    output logic rx_active,
    output logic rx_error
);
    localparam int ZW = $clog2(SYNC_MIN_ZEROS + 1);
    localparam int RW = $clog2(STUFF_RUN + 1);

    frame_state_t state;
    logic [ZW-1:0] zero_cnt;
    logic [RW-1:0] ones_cnt;
    logic sync_hit, eop, viol, stuff_drop;

    always_comb begin
        sync_hit   = 1'b0;
        eop        = 1'b0;
        viol       = 1'b0;
        stuff_drop = 1'b0;
        take       = 1'b0;
        take_val   = sym.value;
        if (sym.strobe) begin
            if (state == ST_HUNT) begin
                sync_hit = !sym.se0 && sym.value && (zero_cnt == ZW'(SYNC_MIN_ZEROS));
            end else if (sym.se0) begin
                eop = 1'b1;
            end else if (!raw_mode && ones_cnt == RW'(STUFF_RUN)) begin
                viol       = sym.value;
                stuff_drop = !sym.value;
            end else begin
                take = 1'b1;
            end
        end
        frame_start = sync_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            zero_cnt  <= '0;
            ones_cnt  <= '0;
            rx_active <= 1'b0;
            rx_error  <= 1'b0;
        end else begin
            rx_error <= 1'b0;
            if (state == ST_HUNT) begin
                if (sym.strobe) begin
                    if (sym.se0 || sym.value) begin
                        zero_cnt <= '0;
                    end else if (zero_cnt != ZW'(SYNC_MIN_ZEROS)) begin
                        zero_cnt <= zero_cnt + 1'b1;
                    end
                    if (sync_hit) begin
                        state     <= ST_DATA;
                        rx_active <= 1'b1;
                        ones_cnt  <= raw_mode ? '0 : RW'(1);
                    end
                end
            end else begin
                if (eop || viol) begin
                    state     <= ST_HUNT;
                    rx_active <= 1'b0;
                    zero_cnt  <= '0;
                    rx_error  <= viol;
                end
                if (stuff_drop) begin
                    ones_cnt <= '0;
                end else if (take) begin
                    if (raw_mode || !sym.value) ones_cnt <= '0;
                    else                        ones_cnt <= ones_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxd_byte_pack.sv
module rxd_byte_pack #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic              take_val,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg, shift_nxt;
    logic [CW-1:0]     bit_cnt;

    always_comb shift_nxt = {take_val, shreg[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (take) begin
                shreg <= shift_nxt;
                if (bit_cnt == CW'(DATA_W - 1)) begin
                    bit_cnt  <= '0;
                    rx_data  <= shift_nxt;
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer
    import rxd_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int SYNC_MIN_ZEROS = 5,
    parameter int STUFF_RUN      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              line_bit,
    input  logic              se0,
    input  logic              raw_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_active,
    output logic              rx_error
);
    sym_t sym;
    logic take, take_val, frame_start;

    rxd_line_decode u_decode (
        .clk(clk), .rst(rst), .bit_en(bit_en), .line_bit(line_bit),
        .se0(se0), .raw_mode(raw_mode), .sym(sym)
    );

    rxd_frame_ctrl #(
        .SYNC_MIN_ZEROS(SYNC_MIN_ZEROS), .STUFF_RUN(STUFF_RUN)
    ) u_ctrl (
        .clk(clk), .rst(rst), .sym(sym), .raw_mode(raw_mode),
        .take(take), .take_val(take_val), .frame_start(frame_start),
        .rx_active(rx_active), .rx_error(rx_error)
    );

    rxd_byte_pack #(.DATA_W(DATA_W)) u_pack (
        .clk(clk), .rst(rst), .clear(frame_start), .take(take),
        .take_val(take_val), .rx_data(rx_data), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/rxd_deframer_chk.sv
module rxd_deframer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              line_bit,
    input logic              se0,
    input logic              raw_mode,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_active,
    input logic              rx_error
);
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active); // R3
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_en)); // R3
    AST_NO_SYNC_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> !rx_valid); // R2
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_error |=> !rx_error); // R6
    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> !rx_active); // R6
    AST_SE0_ENDS: assert property (@(posedge clk) disable iff (rst)
        $past(bit_en && se0) |-> !rx_active); // R7
    AST_RAW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> !$past(raw_mode)); // R8
endmodule

bind rxd_deframer rxd_deframer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rxd_deframer_bench.sv
module rxd_deframer_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, line_bit = 1'b1, se0 = 1'b0, raw_mode = 1'b0;
    logic [7:0] rx_data;
    logic rx_valid, rx_active, rx_error;

    int checks = 0, errors = 0, err_pulses = 0;
    logic [7:0] expq[$];
    logic lvl = 1'b1;
    int ones = 0;
    int gap = 1;

    always #10 clk = ~clk;

    rxd_deframer u_rxd_deframer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .line_bit(line_bit), .se0(se0),
        .raw_mode(raw_mode), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_active(rx_active), .rx_error(rx_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on each valid byte, count error pulses
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected byte", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(rx_data == e, "R3/R4 byte", rx_data, e);
            end
        end
        if (!rst && rx_error) err_pulses++;
    end

    task automatic strobe(input logic b, input logic s0);
        line_bit = b; se0 = s0; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_sym(input logic d);
        if (raw_mode) strobe(d, 1'b0);
        else begin
            if (!d) lvl = ~lvl;
            strobe(lvl, 1'b0);
        end
    endtask

    task automatic send_data_bit(input logic d);
        send_sym(d);
        if (!raw_mode) begin
            ones = d ? ones + 1 : 0;
            if (ones == 6) begin   // R5 stuffed zero
                send_sym(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic send_sync();
        for (int i = 0; i < 7; i++) send_sym(1'b0);
        send_sym(1'b1);
        ones = 1;
        check(rx_active == 1'b1, "R2 active after preamble", rx_active, 1);
    endtask

    task automatic send_eop();
        strobe(1'b0, 1'b1);
        strobe(1'b0, 1'b1);
        lvl = 1'b1;
        strobe(1'b1, 1'b0);
    endtask

    task automatic send_packet(input logic [7:0] bytes[$], input int tail);
        send_sync();
        foreach (bytes[k]) begin
            expq.push_back(bytes[k]);
            for (int b = 0; b < 8; b++) send_data_bit(bytes[k][b]);
        end
        for (int t = 0; t < tail; t++) send_data_bit(t[0]);
        send_eop();
        repeat (2) @(negedge clk);
        check(rx_active == 1'b0, "R7 active low after end", rx_active, 0);
        check(expq.size() == 0, "R7 all bytes seen, none extra", expq.size(), 0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] pk[$];
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!rx_active && !rx_valid && !rx_error, "R9 reset outputs",
              {rx_active, rx_valid, rx_error}, 0);

        // R1 R2 R4 spaced strobes
        gap = 1;
        pk = '{8'hA5, 8'h3C, 8'h00, 8'h81};
        send_packet(pk, 0);

        // R5 stuffing with back-to-back strobes
        gap = 0;
        pk = '{8'hFF, 8'hFF, 8'h7E, 8'hFC};
        send_packet(pk, 0);
        check(err_pulses == 0, "R5 no error on stuffed run", err_pulses, 0);

        // R7 partial byte dropped
        gap = 2;
        pk = '{8'h12};
        send_packet(pk, 3);

        // R8 raw mode: long ones, no removal, no error
        gap = 0;
        raw_mode = 1'b1;
        pk = '{8'hFF, 8'hFF, 8'h00, 8'h80};
        send_packet(pk, 0);
        check(err_pulses == 0, "R8 raw mode no error", err_pulses, 0);
        raw_mode = 1'b0;
        lvl = 1'b1;

        // R6 stuffing violation
        gap = 1;
        e0 = err_pulses;
        send_sync();
        expq.push_back(8'h00);
        for (int b = 0; b < 8; b++) send_data_bit(1'b0);
        for (int i = 0; i < 7; i++) send_sym(1'b1);
        check(err_pulses == e0 + 1, "R6 one error pulse", err_pulses, e0 + 1);
        check(rx_active == 1'b0, "R6 active dropped", rx_active, 0);
        send_eop();
        check(expq.size() == 0, "R6 byte before error delivered", expq.size(), 0);

        // R6 recovery, R1 idle level after SE0
        pk = '{8'hC3, 8'h5A};
        send_packet(pk, 0);
        check(err_pulses == e0 + 1, "R6 no further error", err_pulses, e0 + 1);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule